// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Checker

This block sits behind an E1 frame aligner. Once basic frame alignment holds, it reads bit 1 of timeslot 0 of every frame and finds the 16-frame CRC-4 multiframe from the alignment word carried in the frames without the frame alignment signal. It then checks each half of the multiframe, an 8-frame block, against the CRC-4 remainder that the far end sends in the following half. Mismatches go into an error counter that the host can read.

The upstream aligner supplies one bit per `bit_valid` cycle. It also supplies a `frame_start` mark on the first bit of each frame and an `nfas` flag that tells whether that frame carries no frame alignment signal. The host turns the checker on with `en` and chooses an 8-bit or 10-bit counter range with `wide_cnt`. A read pulse on `cnt_clr` clears the counter. The multiframe flag and the start strobe let downstream logic lock onto multiframe boundaries.

Top module: `e1_crc4_mf_checker`

## Requirements
- R1: After reset, `mf_aligned` and `mf_start` are 0 and `crc_err_cnt` is 0.
- R2: Bit 1 of frames 1, 3, 5, 7, 9 and 11 carries the word 0,0,1,0,1,1 in that order. The block sets `mf_aligned` in the cycle after bit 1 of frame 11 is accepted, but only in the second of two consecutive multiframes that both carry the word. A single multiframe with the word does not set it.
- R3: While aligned, `mf_start` is high for exactly one cycle, in the cycle after bit 1 of frame 0 is accepted. It is never high while not aligned.
- R4: The CRC-4 uses the polynomial x^4+x+1 and is computed over each 8-frame block, frames 0-7 or frames 8-15. Bit 1 of every even frame is taken as 0 in this computation. The block collects the bits received in bit 1 of the even frames of the next block as C1 (frame 0 or 8, the x^3 coefficient), then C2, C3 and C4 (frame 6 or 14). If these bits differ from the computed remainder, the counter rises by one in the cycle after bit 1 of frame 6 or 14 is accepted.
- R5: A block with several corrupted bits adds at most one to the counter.
- R6: No CRC error is counted while `mf_aligned` is 0.
- R7: With `wide_cnt`=0 the counter saturates at 255.
- R8: With `wide_cnt`=1 the counter saturates at 1023.
- R9: `cnt_clr` sets the counter to 0 in the next cycle. If an error is counted in the same cycle, the counter becomes 1.
- R10: One multiframe without the alignment word leaves `mf_aligned` set. Two consecutive such multiframes clear it in the cycle after bit 1 of frame 11 of the second one is accepted.
- R11: When `en` or `frame_sync` is low, `mf_aligned` and `mf_start` are 0 from the next cycle, the search restarts, and the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Host enable for multiframe mode |
| wide_cnt | input | 1 | 1 selects the 10-bit counter range, 0 the 8-bit range |
| frame_sync | input | 1 | Basic frame alignment is held upstream |
| bit_valid | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received E1 bit |
| frame_start | input | 1 | This bit is bit 1 of timeslot 0 |
| nfas | input | 1 | With `frame_start`: the frame carries no frame alignment signal |
| cnt_clr | input | 1 | Host read strobe; clears the counter |
| mf_aligned | output | 1 | Multiframe alignment found |
| mf_start | output | 1 | One-cycle pulse at the start of each multiframe |
| crc_err_cnt | output | CNT_W | CRC error count |

## Verification
Every result the block produces is registered once. The alignment flag, the start strobe and each counter step appear in the cycle after the clock edge that takes in the frame-start bit that causes them. A clear or a disable shows one cycle after the edge that samples it. The driver drives each bit just after a rising edge, so the bit is consumed at the next edge. For the frame-start bit and the bit after it, the driver queues the expected outputs with a due cycle two falling edges later. The monitor compares those items on that falling edge. This keeps every comparison clear of the edge where the outputs change.

// File: rtl/e1_crc4_mf_checker.sv
module e1_crc4_mf_checker #(
  parameter int CNT_W    = 10,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wide_cnt,
  input  logic             frame_sync,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             frame_start,
  input  logic             nfas,
  input  logic             cnt_clr,
  output logic             mf_aligned,
  output logic             mf_start,
  output logic [CNT_W-1:0] crc_err_cnt
);

  localparam int FW = 4;
  localparam int SW = 3;
  localparam logic [5:0]    MFA_WORD  = 6'b001011;
  localparam logic [FW-1:0] CHK_FRAME = 4'd11;
  localparam logic [SW-1:0] LAST_C    = 3'd6;
  localparam logic [CNT_W-1:0] WIDE_MAX   = '1;
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << NARROW_W) - 1);

  logic run, tick, track, cpos, chk, cmp, pat_hit, err_ev, din, cand, miss;
  logic [FW-1:0] fcnt, f_now;
  logic [5:0] sr, sr_nxt;
  logic [3:0] crc, crc_nxt, prev_crc, rxc, rxc_nxt;
  logic [CNT_W-1:0] cnt_max;

  assign run     = en & frame_sync;
  assign tick    = run & bit_valid & frame_start;
  assign track   = mf_aligned | cand;
  assign f_now   = fcnt + 1'b1;
  assign sr_nxt  = {sr[4:0], bit_in};
  assign pat_hit = (sr_nxt == MFA_WORD);
  assign chk     = tick & track & (f_now == CHK_FRAME);
  assign cpos    = tick & track & ~f_now[0];
  assign cmp     = cpos & (f_now[SW-1:0] == LAST_C);
  assign rxc_nxt = {rxc[2:0], bit_in};
  assign err_ev  = cmp & mf_aligned & (rxc_nxt != prev_crc);
  assign din     = cpos ? 1'b0 : bit_in;
  assign crc_nxt = {crc[2:0], 1'b0} ^ {2'b00, din ^ crc[3], din ^ crc[3]};
  assign cnt_max = wide_cnt ? WIDE_MAX : NARROW_MAX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_aligned <= 1'b0;
      mf_start   <= 1'b0;
      cand       <= 1'b0;
      miss       <= 1'b0;
      sr         <= '0;
      fcnt       <= '0;
      crc        <= '0;
      prev_crc   <= '0;
      rxc        <= '0;
    end else if (!run) begin
      mf_aligned <= 1'b0;
      mf_start   <= 1'b0;
      cand       <= 1'b0;
      miss       <= 1'b0;
      sr         <= '0;
      fcnt       <= '0;
    end else begin
      mf_start <= tick & mf_aligned & (f_now == '0);
      if (tick & nfas) sr <= sr_nxt;
      if (tick & ~track & nfas & pat_hit) begin
        cand <= 1'b1;
        fcnt <= CHK_FRAME;
      end else if (tick & track) begin
        fcnt <= f_now;
      end
      if (chk) begin
        if (pat_hit) begin
          mf_aligned <= 1'b1;
          cand       <= 1'b0;
          miss       <= 1'b0;
        end else if (cand) begin
          cand <= 1'b0;
        end else if (miss) begin
          mf_aligned <= 1'b0;
          miss       <= 1'b0;
        end else begin
          miss <= 1'b1;
        end
      end
      if (bit_valid & track) begin
        if (tick & (f_now[SW-1:0] == '0)) begin
          crc      <= '0;
          prev_crc <= crc;
        end else begin
          crc <= crc_nxt;
        end
      end
      if (cpos) rxc <= rxc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      crc_err_cnt <= '0;
    else if (cnt_clr)
      crc_err_cnt <= CNT_W'(err_ev);
    else if (err_ev && crc_err_cnt < cnt_max)
      crc_err_cnt <= crc_err_cnt + 1'b1;
  end

  p_align_at_frame11_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_aligned) |-> $past(tick && f_now == CHK_FRAME));

  p_start_needs_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> mf_aligned);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> !mf_start);

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (crc_err_cnt == $past(crc_err_cnt) || crc_err_cnt == $past(crc_err_cnt) + 1'b1));

  p_hold_unaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_aligned && !cnt_clr) |=> $stable(crc_err_cnt));

  p_narrow_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_cnt && crc_err_cnt <= NARROW_MAX) |=> crc_err_cnt <= NARROW_MAX);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> crc_err_cnt <= CNT_W'(1));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && frame_sync) |=> (!mf_aligned && !mf_start));

endmodule

// File: tb/e1_crc4_mf_checker_tb.sv
`timescale 1ns/1ps
module e1_crc4_mf_checker_tb;
  logic clk = 0, rst_n = 0, en = 0, wide_cnt = 0, frame_sync = 0;
  logic bit_valid = 0, bit_in = 0, frame_start = 0, nfas = 0, cnt_clr = 0;
  logic mf_aligned, mf_start;
  logic [9:0] crc_err_cnt;

  localparam logic [5:0] MFA = 6'b001011;

  typedef struct {
    int    cyc;
    bit    mfs;
    bit    al;
    int    cnt;
    string req;
  } exp_t;

  exp_t q[$];
  int ncyc = 0, n_chk = 0, n_fail = 0, exp_cnt = 0;
  bit finished = 0, cor_prev2 = 0;
  logic [3:0] crc_run = 0, prev_crc = 0;

  e1_crc4_mf_checker u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wide_cnt(wide_cnt), .frame_sync(frame_sync),
    .bit_valid(bit_valid), .bit_in(bit_in), .frame_start(frame_start), .nfas(nfas),
    .cnt_clr(cnt_clr), .mf_aligned(mf_aligned), .mf_start(mf_start), .crc_err_cnt(crc_err_cnt)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] crc_step(logic [3:0] c, logic d);
    return {c[2:0], 1'b0} ^ ((c[3] ^ d) ? 4'b0011 : 4'b0000);
  endfunction

  task automatic check(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    ncyc++;
    if (q.size() > 0 && q[0].cyc == ncyc) begin
      e = q.pop_front();
      check(e.req, "mf_start", int'(mf_start), int'(e.mfs));
      check(e.req, "mf_aligned", int'(mf_aligned), int'(e.al));
      check(e.req, "crc_err_cnt", int'(crc_err_cnt), e.cnt);
    end
  end

  task automatic drive(bit d, bit fs, bit nf, bit clr, bit e, bit s, bit mfs, bit al, string req);
    exp_t x;
    @(posedge clk); #1;
    bit_valid = 1; bit_in = d; frame_start = fs; nfas = nf;
    cnt_clr = clr; en = e; frame_sync = s;
    if (req != "") begin
      x.cyc = ncyc + 2; x.mfs = mfs; x.al = al; x.cnt = exp_cnt; x.req = req;
      q.push_back(x);
    end
  endtask

  task automatic bump(bit counted, bit mm);
    if (counted && mm && exp_cnt < (wide_cnt ? 1023 : 255)) exp_cnt++;
  endtask

  task automatic send_mf(bit good, bit cor1, bit cor2, bit cflip, bit al_in, bit al_out,
                         int rd_f, string req);
    for (int f = 0; f < 16; f++) begin
      for (int i = 0; i < 8; i++) begin
        bit d, tx, clr, al;
        d = 1'($urandom);
        if (i == 0) begin
          if (f % 2 == 0)  d = prev_crc[3 - (f % 8) / 2];
          else if (f <= 11) d = good ? MFA[5 - (f - 1) / 2] : 1'b0;
          else             d = 1'b1;
        end
        crc_run = crc_step(crc_run, (i == 0 && f % 2 == 0) ? 1'b0 : d);
        tx = d ^ ((cor1 && f == 3 && i == 2) || (cor2 && (f == 9 || f == 13) && i == 2)
                  || (cflip && f == 8 && i == 0));
        clr = (i == 0 && f == rd_f);
        if (clr) exp_cnt = 0;
        if (i == 0 && f == 6)  bump(al_in, cor_prev2);
        if (i == 0 && f == 14) bump(al_out, cor1 || cflip);
        al = (f >= 11) ? al_out : al_in;
        drive(tx, i == 0, f % 2 == 1, clr, 1, 1, (f == 0 && i == 0 && al_in), al,
              (i <= 1) ? req : "");
        if (i == 7 && f % 8 == 7) begin
          prev_crc = crc_run;
          crc_run  = 0;
        end
      end
    end
    cor_prev2 = cor2;
  endtask

  task automatic idle(int n, bit e, bit s, string req);
    for (int k = 0; k < n; k++) drive(1'($urandom), 0, 0, 0, e, s, 0, 0, req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", "mf_aligned", int'(mf_aligned), 0);
    check("R1", "mf_start", int'(mf_start), 0);
    check("R1", "crc_err_cnt", int'(crc_err_cnt), 0);
    send_mf(1, 0, 1, 0, 0, 0, -1, "R6");
    send_mf(1, 0, 0, 0, 0, 1, -1, "R2");
    send_mf(1, 0, 0, 0, 1, 1, -1, "R3");
    send_mf(1, 1, 0, 0, 1, 1, -1, "R4");
    send_mf(1, 0, 1, 0, 1, 1, -1, "R5");
    send_mf(1, 0, 0, 0, 1, 1, -1, "R5");
    send_mf(1, 0, 0, 1, 1, 1, -1, "R4");
    send_mf(1, 0, 0, 0, 1, 1, 3, "R9");
    send_mf(1, 1, 0, 0, 1, 1, 14, "R9");
    send_mf(0, 0, 0, 0, 1, 1, -1, "R10");
    send_mf(1, 0, 0, 0, 1, 1, -1, "R10");
    send_mf(0, 0, 0, 0, 1, 1, -1, "R10");
    send_mf(0, 0, 0, 0, 1, 0, -1, "R10");
    send_mf(1, 1, 0, 0, 0, 0, -1, "R6");
    send_mf(1, 0, 0, 0, 0, 1, -1, "R2");
    idle(12, 0, 1, "R11");
    send_mf(1, 0, 0, 0, 0, 0, -1, "R11");
    send_mf(1, 0, 0, 0, 0, 1, -1, "R11");
    idle(12, 1, 0, "R11");
    send_mf(1, 0, 0, 0, 0, 0, -1, "R11");
    send_mf(1, 0, 0, 0, 0, 1, -1, "R11");
    for (int m = 0; m < 130; m++) send_mf(1, 1, 1, 0, 1, 1, -1, "R7");
    wide_cnt = 1;
    for (int m = 0; m < 400; m++) send_mf(1, 1, 1, 0, 1, 1, -1, "R8");
    send_mf(1, 0, 0, 0, 1, 1, 0, "R9");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule